// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Almost Flags

This block is a first-in first-out buffer for 9-bit words that sits between two independent clock domains. The producer side writes on its own clock whenever a pair of write enables is in the active state. The consumer side reads on a second clock whenever its pair of read enables is active. Either enable in each pair can be given to system control while the other is driven by expansion or gating logic.

Four status flags report the fill level: empty and almost-empty belong to the read clock, and full and almost-full belong to the write clock. Each flag is a register that changes only on the edges of the clock that owns it. The almost thresholds are offsets held in two small registers, one per domain. They come out of reset at 7 words and can be reloaded at any time through a load strobe in the owning domain. Pointers cross between domains as Gray codes through two-flop synchronizers. The flags are therefore conservative: the read side never claims data it has not seen, and the write side never claims space it has not seen freed.

Read data is held in an output register. An active-low output enable decides whether that register is driven onto the data port or released. The release is modelled as an all-zero bus with a low drive indication.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on a write-clock rising edge only when `wr_en1_n` is 0, `wr_en2` is 1 and `full` is 0; any other enable combination leaves the contents and flags unchanged.
- R2: A word is taken on a read-clock rising edge only when `rd_en1_n` and `rd_en2_n` are both 0 and `empty` is 0; any other combination leaves `rd_data` unchanged.
- R3: Once the domains have settled, `empty` is 1 exactly when no words are unread, and `full` is 1 exactly when DEPTH words are unread; both are registered in their own clock domain.
- R4: `almost_empty` is 1 when the number of unread words is at most the empty offset, and 0 when it is greater; after reset the empty offset is 7.
- R5: `almost_full` is 1 when the number of unread words is at least DEPTH minus the full offset, and 0 when the number of free places exceeds the full offset; after reset the full offset is 7.
- R6: A high `ae_ofs_load` on a read-clock edge loads `ae_ofs_val` as the empty offset. A high `af_ofs_load` on a write-clock edge loads `af_ofs_val` as the full offset. The new offsets govern the almost flags from then on.
- R7: A write attempted while `full` is 1, or a read attempted while `empty` is 1, is dropped: no pointer moves, no word is lost or duplicated, and `rd_data` holds its value.
- R8: An active-low `rst_n` empties the FIFO: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, output register 0, and both offsets return to their defaults.
- R9: Words leave in the order they were stored. The word taken by a read appears on `rd_data` just after that read-clock edge.
- R10: With `oe_n` at 1, `rd_data` is all zero and `rd_drive` is 0. With `oe_n` at 0, `rd_drive` is 1 and `rd_data` shows the last word read.
- R11: The flags are conservative: when `empty` is 0 at least one word is unread, and when `full` is 0 at least one place is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en1_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Write enable, active high |
| wr_data | input | DW | Word to store |
| af_ofs_load | input | 1 | Load strobe for full offset (write clock) |
| af_ofs_val | input | log2(DEPTH) | New full offset |
| rd_en1_n | input | 1 | Read enable, active low |
| rd_en2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ae_ofs_load | input | 1 | Load strobe for empty offset (read clock) |
| ae_ofs_val | input | log2(DEPTH) | New empty offset |
| rd_data | output | DW | Last read word, zero when released |
| rd_drive | output | 1 | High when rd_data is driven |
| empty | output | 1 | No unread word (read clock) |
| almost_empty | output | 1 | Unread words at or below empty offset (read clock) |
| full | output | 1 | No free place (write clock) |
| almost_full | output | 1 | Free places at or below full offset (write clock) |

## Verification
The bench builds the block with DEPTH of 16, a 9-bit word and the default offsets of 7, so the almost-full edge at 9 words and the full boundary at 16 are reached within a few dozen writes. Both clocks come from a single source in the bench. This keeps the synchronizer latency fixed, so each flag can be compared with the exact word count after a short settle. A later phase loads offsets of 3 and 2, which moves the almost-empty edge to 4 words and the almost-full edge to 14 words.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    localparam int unsigned DCF_DEF_OFS = 7;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
module dcf_sync2 #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
    parameter int unsigned DW    = 9,
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned AF_DEF = dcf_pkg::DCF_DEF_OFS,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en1_n,
    input  logic          en2,
    input  logic          ofs_load,
    input  logic [AW-1:0] ofs_val,
    input  logic [PW-1:0] rgray_sync,
    output logic          fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          almost_full
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [AW-1:0] ofs;
        logic          full;
        logic          afull;
    } wst_t;

    wst_t st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] used;
    logic [PW-1:0] thresh;

    always_comb begin
        st_d   = st_q;
        fire   = !en1_n && en2 && !st_q.full;
        if (ofs_load) st_d.ofs = ofs_val;
        st_d.ptr  = st_q.ptr + PW'(fire);
        st_d.gray = PW'(dcf_pkg::bin2gray(32'(st_d.ptr)));
        rbin      = PW'(dcf_pkg::gray2bin(32'(rgray_sync)));
        used      = st_d.ptr - rbin;
        thresh    = DEPTH_P - PW'(st_d.ofs);
        st_d.full  = (used == DEPTH_P);
        st_d.afull = (used >= thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr   <= '0;
            st_q.gray  <= '0;
            st_q.ofs   <= AW'(AF_DEF);
            st_q.full  <= 1'b0;
            st_q.afull <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr       = st_q.ptr[AW-1:0];
    assign wptr        = st_q.ptr;
    assign wgray       = st_q.gray;
    assign full        = st_q.full;
    assign almost_full = st_q.afull;
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
    parameter int unsigned DW     = 9,
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned AE_DEF = dcf_pkg::DCF_DEF_OFS,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en1_n,
    input  logic          en2_n,
    input  logic          oe_n,
    input  logic          ofs_load,
    input  logic [AW-1:0] ofs_val,
    input  logic [PW-1:0] wgray_sync,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] dout,
    output logic          drive,
    output logic          empty,
    output logic          almost_empty
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [AW-1:0] ofs;
        logic [DW-1:0] word;
        logic          empty;
        logic          aempty;
    } rst_t;

    rst_t st_d, st_q;
    logic          fire;
    logic [PW-1:0] wbin;
    logic [PW-1:0] used;

    always_comb begin
        st_d = st_q;
        fire = !en1_n && !en2_n && !st_q.empty;
        if (ofs_load) st_d.ofs = ofs_val;
        if (fire)     st_d.word = rdata;
        st_d.ptr    = st_q.ptr + PW'(fire);
        st_d.gray   = PW'(dcf_pkg::bin2gray(32'(st_d.ptr)));
        wbin        = PW'(dcf_pkg::gray2bin(32'(wgray_sync)));
        used        = wbin - st_d.ptr;
        st_d.empty  = (used == '0);
        st_d.aempty = (used <= PW'(st_d.ofs));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr    <= '0;
            st_q.gray   <= '0;
            st_q.ofs    <= AW'(AE_DEF);
            st_q.word   <= '0;
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr        = st_q.ptr[AW-1:0];
    assign rptr         = st_q.ptr;
    assign rgray        = st_q.gray;
    assign dout         = oe_n ? '0 : st_q.word;
    assign drive        = !oe_n;
    assign empty        = st_q.empty;
    assign almost_empty = st_q.aempty;
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo #(
    parameter int unsigned DW         = 9,
    parameter int unsigned DEPTH      = 1024,
    parameter int unsigned AE_DEFAULT = dcf_pkg::DCF_DEF_OFS,
    parameter int unsigned AF_DEFAULT = dcf_pkg::DCF_DEF_OFS,
    localparam int unsigned AW        = $clog2(DEPTH),
    localparam int unsigned PW        = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_en1_n,
    input  logic          wr_en2,
    input  logic [DW-1:0] wr_data,
    input  logic          af_ofs_load,
    input  logic [AW-1:0] af_ofs_val,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic          oe_n,
    input  logic          ae_ofs_load,
    input  logic [AW-1:0] ae_ofs_val,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive,
    output logic          empty,
    output logic          almost_empty,
    output logic          full,
    output logic          almost_full
);
    logic          w_fire;
    logic [AW-1:0] w_addr;
    logic [AW-1:0] r_addr;
    logic [PW-1:0] w_ptr;
    logic [PW-1:0] r_ptr;
    logic [PW-1:0] w_gray;
    logic [PW-1:0] r_gray;
    logic [PW-1:0] w_gray_at_r;
    logic [PW-1:0] r_gray_at_w;
    logic [DW-1:0] ram_q;

    dcf_wr_side #(.DEPTH(DEPTH), .AF_DEF(AF_DEFAULT)) u_wr (
        .clk        (wclk),
        .rst_n      (rst_n),
        .en1_n      (wr_en1_n),
        .en2        (wr_en2),
        .ofs_load   (af_ofs_load),
        .ofs_val    (af_ofs_val),
        .rgray_sync (r_gray_at_w),
        .fire       (w_fire),
        .waddr      (w_addr),
        .wptr       (w_ptr),
        .wgray      (w_gray),
        .full       (full),
        .almost_full(almost_full)
    );

    dcf_sync2 #(.W(PW)) u_sync_r2w (
        .clk  (wclk),
        .rst_n(rst_n),
        .d    (r_gray),
        .q    (r_gray_at_w)
    );

    dcf_sync2 #(.W(PW)) u_sync_w2r (
        .clk  (rclk),
        .rst_n(rst_n),
        .d    (w_gray),
        .q    (w_gray_at_r)
    );

    dcf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .wclk (wclk),
        .we   (w_fire),
        .waddr(w_addr),
        .wdata(wr_data),
        .raddr(r_addr),
        .rdata(ram_q)
    );

    dcf_rd_side #(.DW(DW), .DEPTH(DEPTH), .AE_DEF(AE_DEFAULT)) u_rd (
        .clk         (rclk),
        .rst_n       (rst_n),
        .en1_n       (rd_en1_n),
        .en2_n       (rd_en2_n),
        .oe_n        (oe_n),
        .ofs_load    (ae_ofs_load),
        .ofs_val     (ae_ofs_val),
        .wgray_sync  (w_gray_at_r),
        .rdata       (ram_q),
        .raddr       (r_addr),
        .rptr        (r_ptr),
        .rgray       (r_gray),
        .dout        (rd_data),
        .drive       (rd_drive),
        .empty       (empty),
        .almost_empty(almost_empty)
    );
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
    parameter int unsigned DW    = 9,
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en1_n,
    input logic          wr_en2,
    input logic          rd_en1_n,
    input logic          rd_en2_n,
    input logic          oe_n,
    input logic [DW-1:0] rd_data,
    input logic          rd_drive,
    input logic          empty,
    input logic          almost_empty,
    input logic          full,
    input logic          almost_full,
    input logic [PW-1:0] w_ptr,
    input logic [PW-1:0] r_ptr
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    AST_WR_GATED: assert property (@(posedge wclk) disable iff (!rst_n)
        !(!wr_en1_n && wr_en2) |=> (w_ptr == $past(w_ptr))); // R1

    AST_RD_GATED: assert property (@(posedge rclk) disable iff (!rst_n)
        !(!rd_en1_n && !rd_en2_n) |=> (r_ptr == $past(r_ptr))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        full |=> (w_ptr == $past(w_ptr))); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |=> (r_ptr == $past(r_ptr))); // R7

    AST_FULL_HAS_AF: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> almost_full); // R5

    AST_EMPTY_HAS_AE: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |-> almost_empty); // R4

    AST_PTR_GAP: assert property (@(posedge wclk) disable iff (!rst_n)
        ((w_ptr - r_ptr) <= DEPTH_P)); // R11

    AST_OE_RELEASE: assert property (@(posedge rclk) disable iff (!rst_n)
        oe_n |-> (!rd_drive && (rd_data == '0))); // R10

    AST_OE_DRIVE: assert property (@(posedge rclk) disable iff (!rst_n)
        !oe_n |-> rd_drive); // R10
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .wclk        (wclk),
    .rclk        (rclk),
    .rst_n       (rst_n),
    .wr_en1_n    (wr_en1_n),
    .wr_en2      (wr_en2),
    .rd_en1_n    (rd_en1_n),
    .rd_en2_n    (rd_en2_n),
    .oe_n        (oe_n),
    .rd_data     (rd_data),
    .rd_drive    (rd_drive),
    .empty       (empty),
    .almost_empty(almost_empty),
    .full        (full),
    .almost_full (almost_full),
    .w_ptr       (w_ptr),
    .r_ptr       (r_ptr)
);

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;
    localparam int DW    = 9;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          wr_en1_n, wr_en2, rd_en1_n, rd_en2_n, oe_n;
    logic [DW-1:0] wr_data;
    logic          af_ofs_load, ae_ofs_load;
    logic [AW-1:0] af_ofs_val, ae_ofs_val;
    logic [DW-1:0] rd_data;
    logic          rd_drive, empty, almost_empty, full, almost_full;

    dcf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .wclk(clk), .rclk(clk), .rst_n(rst_n),
        .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .wr_data(wr_data),
        .af_ofs_load(af_ofs_load), .af_ofs_val(af_ofs_val),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
        .ae_ofs_load(ae_ofs_load), .ae_ofs_val(ae_ofs_val),
        .rd_data(rd_data), .rd_drive(rd_drive), .empty(empty),
        .almost_empty(almost_empty), .full(full), .almost_full(almost_full)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    int            aeo = 7;
    int            afo = 7;
    bit            pess_on = 1'b0;
    logic [DW-1:0] model_q[$];
    logic [DW-1:0] last_word = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_ae(input int cnt);
        return cnt <= aeo;
    endfunction

    function automatic bit exp_af(input int cnt);
        return cnt >= (DEPTH - afo);
    endfunction

    // one cycle, entered and left at a falling edge
    task automatic cyc(input bit w1n, input bit w2, input logic [DW-1:0] d,
                       input bit r1n, input bit r2n);
        bit wacc, racc;
        logic [DW-1:0] e;
        wr_en1_n = w1n; wr_en2 = w2; wr_data = d;
        rd_en1_n = r1n; rd_en2_n = r2n;
        if (pess_on) begin
            if (!empty) check("R11 empty low with data", 32'(model_q.size() > 0), 32'd1);
            if (!full)  check("R11 full low with space", 32'(model_q.size() < DEPTH), 32'd1);
        end
        wacc = !w1n && w2 && !full;
        racc = !r1n && !r2n && !empty;
        e = '0;
        @(posedge clk);
        #1;
        if (racc) begin
            e = model_q.pop_front();
            last_word = e;
        end
        if (wacc) model_q.push_back(d);
        @(negedge clk);
        if (racc) check("R9 read order", 32'(rd_data), 32'(e));
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b1, 1'b0, '0, 1'b1, 1'b1);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        cyc(1'b0, 1'b1, d, 1'b1, 1'b1);
    endtask

    task automatic rd();
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic flags(input string ae_req, input string af_req);
        int cnt;
        idle(6);
        cnt = model_q.size();
        check("R3 empty", 32'(empty), 32'(cnt == 0));
        check("R3 full", 32'(full), 32'(cnt == DEPTH));
        check(ae_req, 32'(almost_empty), 32'(exp_ae(cnt)));
        check(af_req, 32'(almost_full), 32'(exp_af(cnt)));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        wr_en1_n = 1'b1; wr_en2 = 1'b0; wr_data = '0;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1; oe_n = 1'b0;
        af_ofs_load = 1'b0; ae_ofs_load = 1'b0; af_ofs_val = '0; ae_ofs_val = '0;
        repeat (4) @(negedge clk);
        // R8 reset state
        check("R8 empty", 32'(empty), 32'd1);
        check("R8 almost_empty", 32'(almost_empty), 32'd1);
        check("R8 full", 32'(full), 32'd0);
        check("R8 almost_full", 32'(almost_full), 32'd0);
        check("R8 rd_data", 32'(rd_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 gating: inactive enable pairs store nothing
        cyc(1'b1, 1'b1, 9'h055, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 9'h066, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 9'h077, 1'b1, 1'b1);
        flags("R1 almost_empty after gated writes", "R1 almost_full after gated writes");

        // R4 default empty offset, R5 default full offset
        for (int i = 0; i < 7; i++) wr(9'(9'h100 + i));
        flags("R4 almost_empty at 7", "R5 almost_full at 7");
        wr(9'h107);
        flags("R4 almost_empty at 8", "R5 almost_full at 8");
        wr(9'h108);
        flags("R4 almost_empty at 9", "R5 almost_full at 9");
        for (int i = 9; i < DEPTH; i++) wr(9'(9'h100 + i));
        flags("R4 almost_empty at full", "R5 almost_full at full");

        // R7 overflow write dropped
        wr(9'h1AA);
        wr(9'h1AB);
        flags("R7 almost_empty after overflow", "R7 almost_full after overflow");

        // R2 read gating with a partially active pair
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, '0, 1'b1, 1'b0);
        check("R2 rd_data held", 32'(rd_data), 32'(last_word));
        flags("R2 almost_empty after gated reads", "R2 almost_full after gated reads");

        // R9 drain in order
        repeat (DEPTH + 4) rd();
        flags("R9 almost_empty drained", "R9 almost_full drained");

        // R7 underflow read dropped
        rd();
        rd();
        check("R7 rd_data held on empty read", 32'(rd_data), 32'(last_word));

        // R6 load new offsets
        ae_ofs_val = 4'd3; af_ofs_val = 4'd2;
        ae_ofs_load = 1'b1; af_ofs_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ae_ofs_load = 1'b0; af_ofs_load = 1'b0;
        aeo = 3; afo = 2;
        for (int i = 0; i < 3; i++) wr(9'(9'h020 + i));
        flags("R6 almost_empty at 3", "R6 almost_full at 3");
        wr(9'h023);
        flags("R6 almost_empty at 4", "R6 almost_full at 4");
        for (int i = 4; i < 13; i++) wr(9'(9'h020 + i));
        flags("R6 almost_empty at 13", "R6 almost_full at 13");
        wr(9'h02D);
        flags("R6 almost_empty at 14", "R6 almost_full at 14");
        repeat (DEPTH + 4) rd();

        // R10 output release
        oe_n = 1'b1;
        #1;
        check("R10 released data", 32'(rd_data), 32'd0);
        check("R10 released drive", 32'(rd_drive), 32'd0);
        oe_n = 1'b0;
        #1;
        check("R10 driven data", 32'(rd_data), 32'(last_word));
        check("R10 driven drive", 32'(rd_drive), 32'd1);
        @(negedge clk);

        // random traffic, write-heavy then read-heavy
        pess_on = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            bit hv;
            bit w1n, w2, r1n, r2n;
            hv  = (k < 2000);
            w1n = ($urandom_range(0, 9) < (hv ? 2 : 6));
            w2  = ($urandom_range(0, 9) != 0);
            r1n = ($urandom_range(0, 9) < (hv ? 6 : 2));
            r2n = ($urandom_range(0, 9) == 0);
            cyc(w1n, w2, 9'($urandom), r1n, r2n);
        end
        flags("R4 almost_empty after random", "R5 almost_full after random");
        repeat (DEPTH + 4) rd();
        flags("R3 almost_empty final", "R3 almost_full final");

        summary();
        $finish;
    end
endmodule